// File: doc/BRIEF.md
# Masked Break Address Comparator

This block is one break channel of an on-chip debug unit. Software loads a break address and a bit mask, each as two half-word registers, through a small register port. Every bus cycle that the system marks valid has its address compared against the stored break address. A set mask bit removes that address bit from the comparison. When all remaining bits agree and the channel is enabled, the block raises a single-cycle hit pulse one clock later.

A mode control chooses how the address is interpreted. In linear mode the full word is compared. In split data-memory mode the upper half carries an X-memory address and the lower half a Y-memory address. A select bit then picks which half is compared. The other half is treated as always agreeing, whatever its contents or mask.

Register select codes on `cfg_sel` / `cfg_rsel` are: 0 break address upper half, 1 break address lower half, 2 mask upper half, 3 mask lower half, 4 control. The control register uses bit 0 for channel enable, bit 1 for split mode enable and bit 2 for split half select (0 = upper/X, 1 = lower/Y).

Top module: `brk_addr_match`

## Requirements
- R1: After reset, every register (select codes 0 to 4) reads as zero and `brk_hit` is low.
- R2: A write to select code 0, 1, 2 or 3 stores `cfg_wdata` in that half. The half then reads back the last value written to it.
- R3: In linear mode (control bit 1 = 0), with all mask bits 0, a valid strobe produces a hit only if all address bits equal the break address.
- R4: A mask bit of 1 excludes the corresponding address bit from the comparison, in both halves independently. A mask bit of 0 includes it.
- R5: In split mode with select 0, only the upper half is compared under the upper mask. The lower half of the address and the lower mask have no effect.
- R6: In split mode with select 1, only the lower half is compared under the lower mask. The upper half of the address and the upper mask have no effect.
- R7: `brk_hit` is high for exactly the one cycle after a clock edge at which `bus_valid` was high and the address matched. It is never high after an edge with `bus_valid` low.
- R8: While control bit 0 (enable) is 0, `brk_hit` stays low for every address.
- R9: A register write is first seen by a strobe in the cycle after the write. A strobe in the same cycle as the write uses the previous contents.
- R10: The control register reads back bits 2:0 as written, and its upper bits read as zero. Unused select codes read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for writes |
| cfg_wdata | input | HALF_W | Write data |
| cfg_rsel | input | 3 | Register select for reads |
| cfg_rdata | output | HALF_W | Read data of the selected register (combinational) |
| bus_valid | input | 1 | Bus cycle address is valid this cycle |
| bus_addr | input | 2*HALF_W | Bus cycle address |
| brk_hit | output | 1 | One-cycle match pulse |

## Verification
The hardest case is proving that the half not selected in split mode is really ignored. That half must stay ignored even when its mask is zero and its address bits differ. A miss caused by a single bit can hide behind a mask or behind the other half. The stimulus therefore flips every address bit one at a time against a fixed break pattern. It does this for each mode and several masks, including masks that cover only the half that is ignored. Each result is compared to an arithmetic model. A write issued in the same cycle as a strobe checks the ordering of register updates against comparisons.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR_HI = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_MASK_HI = 3'd2,
    SEL_MASK_LO = 3'd3,
    SEL_CTRL    = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic half_sel;  // 0: upper (X) half, 1: lower (Y) half
    logic split_en;  // split X/Y mode
    logic enable;    // channel enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/brk_regfile.sv
module brk_regfile
  import brk_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        wsel,
  input  logic [HALF_W-1:0] wdata,
  input  logic [2:0]        rsel,
  output logic [HALF_W-1:0] rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output logic [ADDR_W-1:0] brk_mask,
  output ctrl_t             ctrl
);

  logic [HALF_W-1:0] addr_hi_q, addr_lo_q, mask_hi_q, mask_lo_q;
  logic [HALF_W-1:0] addr_hi_d, addr_lo_d, mask_hi_d, mask_lo_d;
  ctrl_t             ctrl_q, ctrl_d;

  logic addr_hi_en, addr_lo_en, mask_hi_en, mask_lo_en, ctrl_en;

  // write decode: clock enables per register
  always_comb begin
    addr_hi_en = we && (wsel == SEL_ADDR_HI);
    addr_lo_en = we && (wsel == SEL_ADDR_LO);
    mask_hi_en = we && (wsel == SEL_MASK_HI);
    mask_lo_en = we && (wsel == SEL_MASK_LO);
    ctrl_en    = we && (wsel == SEL_CTRL);
  end

  // next-state
  always_comb begin
    addr_hi_d = addr_hi_en ? wdata : addr_hi_q;
    addr_lo_d = addr_lo_en ? wdata : addr_lo_q;
    mask_hi_d = mask_hi_en ? wdata : mask_hi_q;
    mask_lo_d = mask_lo_en ? wdata : mask_lo_q;
    ctrl_d    = ctrl_en    ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      ctrl_q    <= '0;
    end else begin
      addr_hi_q <= addr_hi_d;
      addr_lo_q <= addr_lo_d;
      mask_hi_q <= mask_hi_d;
      mask_lo_q <= mask_lo_d;
      ctrl_q    <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (rsel)
      SEL_ADDR_HI: rdata = addr_hi_q;
      SEL_ADDR_LO: rdata = addr_lo_q;
      SEL_MASK_HI: rdata = mask_hi_q;
      SEL_MASK_LO: rdata = mask_lo_q;
      SEL_CTRL:    rdata[CTRL_W-1:0] = ctrl_q;
      default:     rdata = '0;
    endcase
  end

  assign brk_addr = {addr_hi_q, addr_lo_q};
  assign brk_mask = {mask_hi_q, mask_lo_q};
  assign ctrl     = ctrl_q;

endmodule

// File: rtl/brk_half_cmp.sv
module brk_half_cmp #(
  parameter int HALF_W   = 16,
  parameter bit IS_UPPER = 1'b0
) (
  input  logic [HALF_W-1:0] bus_half,
  input  logic [HALF_W-1:0] brk_half,
  input  logic [HALF_W-1:0] mask_half,
  input  logic              split_en,
  input  logic              half_sel,
  output logic              half_ok
);

  logic diff_any;
  logic forced;

  always_comb begin
    diff_any = |((bus_half ^ brk_half) & ~mask_half);
    // in split mode the unselected half is forced to agree
    if (IS_UPPER) forced = split_en &&  half_sel;
    else          forced = split_en && !half_sel;
    half_ok = forced || !diff_any;
  end

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match
  import brk_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int ADDR_W = 2 * HALF_W,
  localparam int NHALF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [HALF_W-1:0] cfg_wdata,
  input  logic [2:0]        cfg_rsel,
  output logic [HALF_W-1:0] cfg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              brk_hit
);

  logic              rst_n_sync;
  logic [ADDR_W-1:0] brk_addr;
  logic [ADDR_W-1:0] brk_mask;
  ctrl_t             ctrl;
  logic [NHALF-1:0]  half_ok;
  logic              hit_d, hit_q;

  brk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  brk_regfile #(.HALF_W(HALF_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .we       (cfg_we),
    .wsel     (cfg_sel),
    .wdata    (cfg_wdata),
    .rsel     (cfg_rsel),
    .rdata    (cfg_rdata),
    .brk_addr (brk_addr),
    .brk_mask (brk_mask),
    .ctrl     (ctrl)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    brk_half_cmp #(.HALF_W(HALF_W), .IS_UPPER(h == NHALF-1)) u_cmp (
      .bus_half  (bus_addr[h*HALF_W +: HALF_W]),
      .brk_half  (brk_addr[h*HALF_W +: HALF_W]),
      .mask_half (brk_mask[h*HALF_W +: HALF_W]),
      .split_en  (ctrl.split_en),
      .half_sel  (ctrl.half_sel),
      .half_ok   (half_ok[h])
    );
  end

  always_comb begin
    hit_d = bus_valid && ctrl.enable && (&half_ok);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) hit_q <= 1'b0;
    else             hit_q <= hit_d;
  end

  assign brk_hit = hit_q;

endmodule

// File: rtl/brk_addr_match_chk.sv
module brk_addr_match_chk
  import brk_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int ADDR_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_sel,
  input logic [HALF_W-1:0] cfg_wdata,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [ADDR_W-1:0] brk_addr,
  input logic [ADDR_W-1:0] brk_mask,
  input ctrl_t             ctrl,
  input logic              brk_hit
);

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |-> $past(bus_valid));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_hit);

  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |=> !brk_hit);

  p_mask_lo_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_MASK_LO) |=> brk_mask[HALF_W-1:0] == $past(cfg_wdata));

  p_addr_hi_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_ADDR_HI) |=> brk_addr[ADDR_W-1:HALF_W] == $past(cfg_wdata));

  p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && ctrl.enable && bus_addr == brk_addr) |=> brk_hit);

endmodule

bind brk_addr_match brk_addr_match_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .bus_valid (bus_valid),
  .bus_addr  (bus_addr),
  .brk_addr  (brk_addr),
  .brk_mask  (brk_mask),
  .ctrl      (ctrl),
  .brk_hit   (brk_hit)
);

// File: tb/brk_addr_match_test.sv
`timescale 1ns/1ps
module brk_addr_match_test;

  localparam int HW = 16;
  localparam int AW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = 3'd0;
  logic [HW-1:0] cfg_wdata = '0;
  logic [2:0]    cfg_rsel = 3'd0;
  logic [HW-1:0] cfg_rdata;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          brk_hit;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] s_addr = '0;
  logic [AW-1:0] s_mask = '0;
  logic [2:0]    s_ctrl = '0;

  always #2.5 clk = ~clk;

  brk_addr_match #(.HALF_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .brk_hit(brk_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model(input logic [AW-1:0] a);
    bit hi_ok, lo_ok;
    hi_ok = (((a[AW-1:HW] ^ s_addr[AW-1:HW]) & ~s_mask[AW-1:HW]) == '0);
    lo_ok = (((a[HW-1:0] ^ s_addr[HW-1:0]) & ~s_mask[HW-1:0]) == '0);
    if (!s_ctrl[0]) return 1'b0;
    if (!s_ctrl[1]) return hi_ok && lo_ok;
    if (!s_ctrl[2]) return hi_ok;
    return lo_ok;
  endfunction

  function automatic void shadow(input logic [2:0] sel, input logic [HW-1:0] d);
    case (sel)
      3'd0: s_addr[AW-1:HW] = d;
      3'd1: s_addr[HW-1:0]  = d;
      3'd2: s_mask[AW-1:HW] = d;
      3'd3: s_mask[HW-1:0]  = d;
      3'd4: s_ctrl = d[2:0];
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [HW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow(sel, d);
  endtask

  task automatic rd(input string req, input logic [2:0] sel, input logic [HW-1:0] exp);
    cfg_rsel = sel;
    #1;
    check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic strobe(input string req, input logic [AW-1:0] a);
    bit exp;
    exp = model(a);
    bus_valid = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(req, 32'(brk_hit), 32'(exp));
    @(negedge clk);
    check("R7", 32'(brk_hit), 32'd0);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [AW-1:0] m, input logic [2:0] c);
    wr(3'd0, a[AW-1:HW]); wr(3'd1, a[HW-1:0]);
    wr(3'd2, m[AW-1:HW]); wr(3'd3, m[HW-1:0]);
    wr(3'd4, {13'd0, c});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] masks [3];
    string tag;
    masks[0] = 32'h0000_0000;
    masks[1] = 32'h0F0F_00F0;
    masks[2] = 32'h0000_FFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 5; s++) rd("R1", 3'(s), '0);
    check("R1", 32'(brk_hit), 32'd0);

    // R2 / R10: readback
    wr(3'd0, 16'hBEEF); wr(3'd1, 16'h1234); wr(3'd2, 16'h8001); wr(3'd3, 16'h7FFE);
    wr(3'd4, 16'hFFFA);
    rd("R2", 3'd0, 16'hBEEF); rd("R2", 3'd1, 16'h1234);
    rd("R2", 3'd2, 16'h8001); rd("R2", 3'd3, 16'h7FFE);
    rd("R10", 3'd4, 16'h0002); rd("R10", 3'd6, 16'h0000);

    // R8: disabled channel never hits
    load(32'hA5C3_1E78, 32'h0, 3'b000);
    strobe("R8", 32'hA5C3_1E78);
    strobe("R8", 32'h0000_0000);

    // R7: no strobe, matching address, no hit
    wr(3'd4, 16'h0001);
    bus_addr = 32'hA5C3_1E78;
    @(negedge clk);
    check("R7", 32'(brk_hit), 32'd0);

    // Sweep: modes x masks x single-bit flips
    for (int md = 0; md < 3; md++) begin
      for (int mi = 0; mi < 3; mi++) begin
        logic [2:0] c;
        c = (md == 0) ? 3'b001 : (md == 1) ? 3'b011 : 3'b111;
        load(32'hA5C3_1E78, masks[mi], c);
        tag = (md == 1) ? "R5" : (md == 2) ? "R6" : (mi == 0) ? "R3" : "R4";
        strobe(tag, 32'hA5C3_1E78);
        for (int b = 0; b < AW; b++) strobe(tag, 32'hA5C3_1E78 ^ (32'd1 << b));
        strobe(tag, ~32'hA5C3_1E78);
      end
    end

    // R9: write and strobe in the same cycle use old contents
    load(32'h1111_2222, 32'h0, 3'b001);
    begin
      bit exp_old;
      exp_old = model(32'h1111_2222);
      cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 16'h3333;
      bus_valid = 1'b1; bus_addr = 32'h1111_2222;
      @(negedge clk);
      cfg_we = 1'b0; bus_valid = 1'b0;
      shadow(3'd1, 16'h3333);
      check("R9", 32'(brk_hit), 32'(exp_old));
      @(negedge clk);
    end
    strobe("R9", 32'h1111_3333);
    strobe("R9", 32'h1111_2222);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule